// File: doc/BRIEF.md
# Single-Bus Microstep Datapath Sequencer

This block is a small 32-bit processor datapath. Every transfer between its registers goes over one shared internal bus. It holds eight general registers, a program counter, an instruction register, two scratch registers (one feeds the ALU, one takes the ALU result), and a memory address and memory data register pair that connect it to external memory. A hardwired step counter sets the bus drivers, the register load enables, the ALU input mux and the ALU operation for each clock. Only one source drives the bus in any step, so each instruction runs as a short sequence of such steps.

Each instruction starts with a fixed fetch sequence. The fetch issues the memory read, adds 4 to the program counter in the same step, and waits for memory to complete. It then loads the incremented address into both the program counter and the ALU scratch register, and moves the fetched word into the instruction register. A decode step follows. Execute sequences exist for register add, subtract and exclusive-or, for an add whose second operand is read from memory, and for a PC-relative branch. The branch uses the incremented address that the fetch left in the scratch register. Memory is reached through a level read request and a one-cycle completion pulse. Nothing else can stall the step counter.

Top module: `sbus_core`

## Requirements
- R1: While rst_ni is low, mem_rd_o is low and all eight general registers are cleared. After release, the first clock edge raises mem_rd_o with mem_addr_o equal to RESET_PC (default 0x100).
- R2: Each instruction begins with a read request at the program counter. After any instruction other than a branch, the next request is at that address plus 4. When memory completes in the first wait cycle, fetch and decode together take five cycles, and instructions follow back to back.
- R3: Each additional cycle that memory withholds mem_done_i lengthens the current wait step by exactly one cycle. The step counter and mem_rd_o hold until completion.
- R4: An instruction word holds the opcode in bits 31:26, the destination register in 25:23, the first source in 22:20 and the second source in 19:17. Opcode 1 writes first source plus second source, modulo 2^32, to the destination. The instruction takes 8 cycles plus the fetch wait.
- R5: Opcode 2 writes first source minus second source to the destination. It is computed as the first source plus the inverted second source plus a carry-in of 1, and wraps on underflow. The instruction takes 8 cycles plus the fetch wait.
- R6: Opcode 3 writes first source XOR second source to the destination. The instruction takes 8 cycles plus the fetch wait.
- R7: Opcode 4 issues a data read at the value of the first source register, 5 cycles (plus the fetch wait) after its fetch request. It adds the returned word to the prior value of the destination register, which may be the same register as the first source. The instruction takes 9 cycles plus both waits.
- R8: Opcode 5 is a branch. The next fetch is at the branch address plus 4 plus the sign-extended offset in bits 15:0, which may be zero or negative. The instruction takes 7 cycles plus the fetch wait.
- R9: Any other opcode (including 0 and 63) writes no register and moves on to the next address. The instruction takes 5 cycles plus the fetch wait.
- R10: At most one source drives the internal bus in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_rd_o | output | 1 | Read request, held until completion |
| mem_addr_o | output | XLEN | Byte address of the pending read |
| mem_rdata_i | input | XLEN | Read data, valid with mem_done_i |
| mem_done_i | input | 1 | One-cycle completion of the pending read |

## Verification
The assertions assume that memory raises mem_done_i only while mem_rd_o is high, for a single cycle per request, with mem_rdata_i valid in that same cycle. They also assume that a new request never starts in the cycle a completion is seen. The bench memory model counts a fixed latency from the first cycle it sees a request. It then raises completion for exactly one cycle and drops it before the block can ask again. It also clears itself whenever reset is applied, so no completion is ever offered without a pending request.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int unsigned NREG   = 8;
  localparam int unsigned RIDX_W = $clog2(NREG);
  localparam int unsigned OPC_W  = 6;
  localparam int unsigned OFF_W  = 16;
  localparam int unsigned FLD_W  = OPC_W + 3 * RIDX_W;

  // bus source slots; general registers occupy the top NREG slots
  localparam int unsigned SRC_PC   = 0;
  localparam int unsigned SRC_Z    = 1;
  localparam int unsigned SRC_MDR  = 2;
  localparam int unsigned SRC_OFF  = 3;
  localparam int unsigned SRC_GPR0 = 4;
  localparam int unsigned N_SRC    = SRC_GPR0 + NREG;

  localparam int unsigned STEP_W = 4;
  localparam logic [STEP_W-1:0] ST_ADDR = 4'd0;
  localparam logic [STEP_W-1:0] ST_WAIT = 4'd1;
  localparam logic [STEP_W-1:0] ST_PCUP = 4'd2;
  localparam logic [STEP_W-1:0] ST_IR   = 4'd3;
  localparam logic [STEP_W-1:0] ST_DEC  = 4'd4;
  localparam logic [STEP_W-1:0] ST_X1   = 4'd5;
  localparam logic [STEP_W-1:0] ST_X2   = 4'd6;
  localparam logic [STEP_W-1:0] ST_X3   = 4'd7;
  localparam logic [STEP_W-1:0] ST_X4   = 4'd8;

  localparam logic [OPC_W-1:0] OPC_ADD  = 6'd1;
  localparam logic [OPC_W-1:0] OPC_SUB  = 6'd2;
  localparam logic [OPC_W-1:0] OPC_XOR  = 6'd3;
  localparam logic [OPC_W-1:0] OPC_ADDM = 6'd4;
  localparam logic [OPC_W-1:0] OPC_BR   = 6'd5;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_XOR} alu_op_e;

  typedef struct packed {
    logic    pc_in;
    logic    y_in;
    logic    z_in;
    logic    mar_in;
    logic    mdr_ine;
    logic    ir_in;
    logic    rd_req;
    logic    wait_mfc;
    logic    sel4;
    logic    last;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sbus_alu.sv
module sbus_alu import sbus_pkg::*; #(
  parameter int unsigned XLEN = 32
) (
  input  logic            sel4_i,
  input  logic [XLEN-1:0] y_i,
  input  logic [XLEN-1:0] bus_i,
  input  alu_op_e         op_i,
  output logic [XLEN-1:0] res_o
);
  localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(4);

  logic [XLEN-1:0] a_w;
  logic            cin_w;

  assign a_w   = sel4_i ? WORD_BYTES : y_i;
  assign cin_w = (op_i == ALU_SUB);

  always_comb begin
    case (op_i)
      ALU_SUB: res_o = a_w + ~bus_i + {{(XLEN-1){1'b0}}, cin_w};
      ALU_XOR: res_o = a_w ^ bus_i;
      default: res_o = a_w + bus_i;
    endcase
  end
endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NREG-1:0]            wr_en_i,
  input  logic [XLEN-1:0]            wr_data_i,
  output logic [NREG-1:0][XLEN-1:0]  rd_data_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         rd_data_o[g] <= '0;
      else if (wr_en_i[g]) rd_data_o[g] <= wr_data_i;
    end
  end
endmodule

// File: rtl/sbus_ctrl.sv
module sbus_ctrl import sbus_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FLD_W-1:0]   fld_i,
  input  logic               mem_done_i,
  output ctrl_t              ctrl_o,
  output logic [N_SRC-1:0]   drv_o,
  output logic [NREG-1:0]    gpr_in_o,
  output logic [STEP_W-1:0]  step_o
);
  logic [STEP_W-1:0] step_q;
  logic [OPC_W-1:0]  opc;
  logic [RIDX_W-1:0] rd, rs1, rs2;
  logic              known;

  assign opc = fld_i[FLD_W-1 -: OPC_W];
  assign rd  = fld_i[FLD_W-OPC_W-1 -: RIDX_W];
  assign rs1 = fld_i[FLD_W-OPC_W-RIDX_W-1 -: RIDX_W];
  assign rs2 = fld_i[RIDX_W-1:0];
  assign known = (opc == OPC_ADD) || (opc == OPC_SUB) || (opc == OPC_XOR) ||
                 (opc == OPC_ADDM) || (opc == OPC_BR);

  always_comb begin
    ctrl_o   = '0;
    drv_o    = '0;
    gpr_in_o = '0;
    case (step_q)
      ST_ADDR: begin
        drv_o[SRC_PC] = 1'b1;
        ctrl_o.mar_in = 1'b1;
        ctrl_o.rd_req = 1'b1;
        ctrl_o.sel4   = 1'b1;
        ctrl_o.z_in   = 1'b1;
      end
      ST_WAIT: begin
        ctrl_o.mdr_ine  = 1'b1;
        ctrl_o.wait_mfc = 1'b1;
      end
      ST_PCUP: begin
        drv_o[SRC_Z] = 1'b1;
        ctrl_o.pc_in = 1'b1;
        ctrl_o.y_in  = 1'b1;
      end
      ST_IR: begin
        drv_o[SRC_MDR] = 1'b1;
        ctrl_o.ir_in   = 1'b1;
      end
      ST_DEC: ctrl_o.last = !known;
      default: begin
        case (opc)
          OPC_ADD, OPC_SUB, OPC_XOR: begin
            case (step_q)
              ST_X1: begin
                drv_o[SRC_GPR0 + rs1] = 1'b1;
                ctrl_o.y_in = 1'b1;
              end
              ST_X2: begin
                drv_o[SRC_GPR0 + rs2] = 1'b1;
                ctrl_o.z_in   = 1'b1;
                ctrl_o.alu_op = (opc == OPC_SUB) ? ALU_SUB :
                                (opc == OPC_XOR) ? ALU_XOR : ALU_ADD;
              end
              ST_X3: begin
                drv_o[SRC_Z] = 1'b1;
                gpr_in_o[rd] = 1'b1;
                ctrl_o.last  = 1'b1;
              end
              default: ctrl_o.last = 1'b1;
            endcase
          end
          OPC_ADDM: begin
            case (step_q)
              ST_X1: begin
                drv_o[SRC_GPR0 + rs1] = 1'b1;
                ctrl_o.mar_in = 1'b1;
                ctrl_o.rd_req = 1'b1;
              end
              ST_X2: begin
                drv_o[SRC_GPR0 + rd] = 1'b1;
                ctrl_o.y_in     = 1'b1;
                ctrl_o.mdr_ine  = 1'b1;
                ctrl_o.wait_mfc = 1'b1;
              end
              ST_X3: begin
                drv_o[SRC_MDR] = 1'b1;
                ctrl_o.z_in    = 1'b1;
              end
              ST_X4: begin
                drv_o[SRC_Z] = 1'b1;
                gpr_in_o[rd] = 1'b1;
                ctrl_o.last  = 1'b1;
              end
              default: ctrl_o.last = 1'b1;
            endcase
          end
          OPC_BR: begin
            case (step_q)
              ST_X1: begin
                drv_o[SRC_OFF] = 1'b1;
                ctrl_o.z_in    = 1'b1;
              end
              ST_X2: begin
                drv_o[SRC_Z] = 1'b1;
                ctrl_o.pc_in = 1'b1;
                ctrl_o.last  = 1'b1;
              end
              default: ctrl_o.last = 1'b1;
            endcase
          end
          default: ctrl_o.last = 1'b1;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            step_q <= ST_ADDR;
    else if (ctrl_o.wait_mfc && !mem_done_i) step_q <= step_q;
    else if (ctrl_o.last)                   step_q <= ST_ADDR;
    else                                    step_q <= step_q + 1'b1;
  end

  assign step_o = step_q;
endmodule

// File: rtl/sbus_core.sv
module sbus_core import sbus_pkg::*; #(
  parameter int unsigned    XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0000_0100
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic            mem_rd_o,
  output logic [XLEN-1:0] mem_addr_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  input  logic            mem_done_i
);
  ctrl_t                      ctrl_w;
  logic [N_SRC-1:0]           drv_w;
  logic [NREG-1:0]            gpr_in_w;
  logic [STEP_W-1:0]          step_w;
  logic [N_SRC-1:0][XLEN-1:0] src_w;
  logic [NREG-1:0][XLEN-1:0]  gpr_q;
  logic [XLEN-1:0]            bus_w, alu_w, off_w;
  logic [XLEN-1:0]            pc_q, ir_q, y_q, z_q, mar_q, mdr_q;
  logic                       rd_pend_q;
  logic                       unused_ir_bits;

  sbus_ctrl i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fld_i      (ir_q[XLEN-1 -: FLD_W]),
    .mem_done_i (mem_done_i),
    .ctrl_o     (ctrl_w),
    .drv_o      (drv_w),
    .gpr_in_o   (gpr_in_w),
    .step_o     (step_w)
  );

  sbus_regfile #(.XLEN(XLEN), .NREG(NREG)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (gpr_in_w),
    .wr_data_i (bus_w),
    .rd_data_o (gpr_q)
  );

  sbus_alu #(.XLEN(XLEN)) i_alu (
    .sel4_i (ctrl_w.sel4),
    .y_i    (y_q),
    .bus_i  (bus_w),
    .op_i   (ctrl_w.alu_op),
    .res_o  (alu_w)
  );

  assign off_w = {{(XLEN-OFF_W){ir_q[OFF_W-1]}}, ir_q[OFF_W-1:0]};
  assign unused_ir_bits = ^ir_q[XLEN-FLD_W-1:OFF_W];

  assign src_w[SRC_PC]  = pc_q;
  assign src_w[SRC_Z]   = z_q;
  assign src_w[SRC_MDR] = mdr_q;
  assign src_w[SRC_OFF] = off_w;
  for (genvar g = 0; g < NREG; g++) begin : g_src
    assign src_w[SRC_GPR0 + g] = gpr_q[g];
  end

  always_comb begin
    bus_w = '0;
    for (int i = 0; i < N_SRC; i++)
      if (drv_w[i]) bus_w = bus_w | src_w[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q      <= RESET_PC;
      ir_q      <= '0;
      y_q       <= '0;
      z_q       <= '0;
      mar_q     <= '0;
      mdr_q     <= '0;
      rd_pend_q <= 1'b0;
    end else begin
      if (ctrl_w.pc_in)  pc_q  <= bus_w;
      if (ctrl_w.ir_in)  ir_q  <= bus_w;
      if (ctrl_w.y_in)   y_q   <= bus_w;
      if (ctrl_w.z_in)   z_q   <= alu_w;
      if (ctrl_w.mar_in) mar_q <= bus_w;
      if (ctrl_w.mdr_ine && mem_done_i) mdr_q <= mem_rdata_i;
      if (ctrl_w.rd_req)   rd_pend_q <= 1'b1;
      else if (mem_done_i) rd_pend_q <= 1'b0;
    end
  end

  assign mem_rd_o   = rd_pend_q;
  assign mem_addr_o = mar_q;
endmodule

// File: rtl/sbus_chk.sv
module sbus_chk import sbus_pkg::*; #(
  parameter int unsigned XLEN = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_SRC-1:0]  drv_i,
  input logic [STEP_W-1:0] step_i,
  input logic              wait_i,
  input logic              last_i,
  input logic              mem_rd_i,
  input logic              mem_done_i,
  input logic [XLEN-1:0]   pc_i,
  input logic [XLEN-1:0]   mar_i,
  input logic [XLEN-1:0]   y_i,
  input logic [OPC_W-1:0]  opc_i
);
  assert_bus_single_driver_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(drv_i));

  assert_done_needs_request_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_done_i |-> mem_rd_i);

  assert_wait_holds_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_i && !mem_done_i) |=> $stable(step_i) && mem_rd_i);

  assert_fetch_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == ST_PCUP) |=> (pc_i == $past(mar_i) + XLEN'(4)));

  assert_last_restarts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_i |=> (step_i == ST_ADDR));

  assert_branch_base_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == ST_X1 && opc_i == OPC_BR) |-> (y_i == pc_i));

  assert_req_drops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_i && mem_done_i) |=> !mem_rd_i);
endmodule

bind sbus_core sbus_chk #(.XLEN(XLEN)) i_sbus_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .drv_i      (drv_w),
  .step_i     (step_w),
  .wait_i     (ctrl_w.wait_mfc),
  .last_i     (ctrl_w.last),
  .mem_rd_i   (mem_rd_o),
  .mem_done_i (mem_done_i),
  .pc_i       (pc_q),
  .mar_i      (mar_q),
  .y_i        (y_q),
  .opc_i      (ir_q[XLEN-1 -: sbus_pkg::OPC_W])
);

// File: tb/test_sbus_core.sv
module test_sbus_core;
  localparam logic [31:0] BOOT = 32'h0000_0100;
  localparam int PBASE = 64;
  localparam int TMAX  = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_rd, mem_done;
  logic [31:0] mem_addr, mem_rdata;

  logic [31:0] mem [256];
  logic [31:0] tr_addr [TMAX];
  int          tr_cyc  [TMAX];
  logic [31:0] ex_addr [TMAX];
  int          ex_cyc  [TMAX];
  int tr_n = 0, cyc = 0, lat = 0, n_chk = 0, n_fail = 0;
  bit pend = 0;
  int cnt = 0;

  always #10 clk = ~clk;

  sbus_core #(.XLEN(32), .RESET_PC(BOOT)) i_sbus_core (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mem_rd_o    (mem_rd),
    .mem_addr_o  (mem_addr),
    .mem_rdata_i (mem_rdata),
    .mem_done_i  (mem_done)
  );

  initial forever @(posedge clk) cyc++;

  // memory model: fixed latency, one-cycle completion
  initial begin
    mem_done = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        mem_done = 1'b0;
        pend = 0;
      end else if (mem_done) begin
        mem_done = 1'b0;
      end else if (mem_rd) begin
        if (!pend) begin
          pend = 1;
          cnt = 0;
          if (tr_n < TMAX) begin
            tr_addr[tr_n] = mem_addr;
            tr_cyc[tr_n] = cyc;
          end
          tr_n++;
        end
        if (cnt == lat) begin
          mem_done = 1'b1;
          mem_rdata = mem[mem_addr[9:2]];
          pend = 0;
        end else cnt++;
      end
    end
  end

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ins(logic [5:0] op, int d, int a, int b);
    return {op, 3'(d), 3'(a), 3'(b), 17'b0};
  endfunction

  function automatic logic [31:0] br(int off);
    return {6'd5, 10'd0, 16'(off)};
  endfunction

  task automatic clr_mem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  task automatic do_reset(string req);
    rst_n = 1'b0;
    tr_n = 0;
    repeat (3) @(negedge clk);
    check(mem_rd == 1'b0, req, "request low in reset", {31'b0, mem_rd}, 32'h0);
    tr_n = 0;
    rst_n = 1'b1;
    cyc = 0;
  endtask

  // reference: instruction-level model built from the requirements
  task automatic run_prog(string req, int n_instr, int l);
    logic [31:0] r [8];
    logic [31:0] pc, ir;
    logic [2:0]  d, a, b;
    int c, e;
    for (int i = 0; i < 8; i++) r[i] = '0;
    pc = BOOT; c = 1; e = 0;
    for (int k = 0; k < n_instr; k++) begin
      ex_addr[e] = pc; ex_cyc[e] = c; e++;
      ir = mem[pc[9:2]];
      pc = pc + 32'd4;
      d = ir[25:23]; a = ir[22:20]; b = ir[19:17];
      case (ir[31:26])
        6'd1: begin r[d] = r[a] + r[b]; c += 8 + l; end
        6'd2: begin r[d] = r[a] - r[b]; c += 8 + l; end
        6'd3: begin r[d] = r[a] ^ r[b]; c += 8 + l; end
        6'd4: begin
          ex_addr[e] = r[a]; ex_cyc[e] = c + 5 + l; e++;
          r[d] = r[d] + mem[r[a][9:2]];
          c += 9 + 2 * l;
        end
        6'd5: begin pc = pc + {{16{ir[15]}}, ir[15:0]}; c += 7 + l; end
        default: c += 5 + l;
      endcase
    end
    lat = l;
    do_reset(req);
    for (int w = 0; w < 3000 && tr_n < e; w++) @(negedge clk);
    check(tr_n >= e, req, "request count", 32'(tr_n), 32'(e));
    for (int j = 0; j < e && j < tr_n; j++) begin
      check(tr_addr[j] == ex_addr[j], req, $sformatf("address of request %0d", j), tr_addr[j], ex_addr[j]);
      check(tr_cyc[j] == ex_cyc[j], req, $sformatf("cycle of request %0d", j), 32'(tr_cyc[j]), 32'(ex_cyc[j]));
    end
  endtask

  // R1: reset state and first fetch address/cycle
  task automatic t_reset();
    clr_mem();
    run_prog("R1", 2, 0);
  endtask

  // R2: sequential fetch, back to back
  task automatic t_fetch();
    clr_mem();
    for (int i = 0; i < 4; i++) mem[PBASE+i] = ins(6'd1, 0, 0, 0);
    run_prog("R2", 4, 0);
  endtask

  // R3: slow memory stretches each wait
  task automatic t_wait();
    clr_mem();
    mem[0] = 32'h0000_000C;
    mem[PBASE]   = ins(6'd1, 0, 0, 0);
    mem[PBASE+1] = ins(6'd4, 1, 0, 0);
    mem[PBASE+2] = ins(6'd4, 2, 1, 0);
    run_prog("R3", 3, 3);
  endtask

  // R4: add with carry wrap, rd==rs1==rs2
  task automatic t_add();
    clr_mem();
    mem[0] = 32'h0000_0008;
    mem[2] = 32'hFFFF_FFF0;
    mem[PBASE]   = ins(6'd4, 1, 0, 0);
    mem[PBASE+1] = ins(6'd4, 2, 1, 0);
    mem[PBASE+2] = ins(6'd1, 3, 1, 2);
    mem[PBASE+3] = ins(6'd4, 4, 3, 0);
    mem[PBASE+4] = ins(6'd1, 3, 3, 3);
    mem[PBASE+5] = ins(6'd4, 4, 3, 0);
    run_prog("R4", 6, 1);
  endtask

  // R5: subtract both orders, underflow
  task automatic t_sub();
    clr_mem();
    mem[0] = 32'h0000_0008;
    mem[2] = 32'h0000_0020;
    mem[PBASE]   = ins(6'd4, 1, 0, 0);
    mem[PBASE+1] = ins(6'd4, 2, 1, 0);
    mem[PBASE+2] = ins(6'd2, 3, 1, 2);
    mem[PBASE+3] = ins(6'd2, 5, 2, 1);
    mem[PBASE+4] = ins(6'd4, 6, 3, 0);
    mem[PBASE+5] = ins(6'd4, 6, 5, 0);
    run_prog("R5", 6, 0);
  endtask

  // R6: xor, self-xor clears
  task automatic t_xor();
    clr_mem();
    mem[0] = 32'h0000_0008;
    mem[2] = 32'hA5A5_0F0C;
    mem[PBASE]   = ins(6'd4, 1, 0, 0);
    mem[PBASE+1] = ins(6'd4, 2, 1, 0);
    mem[PBASE+2] = ins(6'd3, 3, 1, 2);
    mem[PBASE+3] = ins(6'd3, 4, 3, 3);
    mem[PBASE+4] = ins(6'd4, 5, 3, 0);
    mem[PBASE+5] = ins(6'd4, 5, 4, 0);
    run_prog("R6", 6, 0);
  endtask

  // R7: memory operand, destination equals address register
  task automatic t_addm();
    clr_mem();
    mem[0] = 32'h0000_0010;
    mem[4] = 32'h0000_0024;
    mem[13] = 32'h1357_9BDF;
    mem[PBASE]   = ins(6'd4, 1, 0, 0);
    mem[PBASE+1] = ins(6'd4, 1, 1, 0);
    mem[PBASE+2] = ins(6'd4, 7, 1, 0);
    mem[PBASE+3] = ins(6'd4, 2, 7, 0);
    run_prog("R7", 4, 2);
  endtask

  // R8: forward, zero and backward offsets
  task automatic t_branch();
    clr_mem();
    mem[PBASE]   = br(4);
    mem[PBASE+1] = ins(6'd4, 1, 0, 0);
    mem[PBASE+2] = br(0);
    mem[PBASE+3] = br(-16);
    run_prog("R8", 7, 1);
  endtask

  // R9: undefined opcodes write nothing
  task automatic t_nop();
    clr_mem();
    mem[0] = 32'h0000_0040;
    mem[PBASE]   = 32'h0000_0000;
    mem[PBASE+1] = {6'h3F, 3'd1, 3'd0, 3'd0, 17'h1FFFF};
    mem[PBASE+2] = ins(6'd4, 2, 1, 0);
    mem[PBASE+3] = ins(6'd4, 3, 2, 0);
    run_prog("R9", 4, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_fetch();
        t_wait();
        t_add();
        t_sub();
        t_xor();
        t_addm();
        t_branch();
        t_nop();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule